// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Token Array

This block holds a small set of one-bit ownership tokens shared between two ports, called left and right. Software on either side uses a token to claim a shared resource. To ask for a token it writes 0 to it. It then reads the token back to learn whether the claim succeeded. To give the token up it writes 1. Both ports run on one common clock. Each port has a semaphore select, a memory chip enable, a write strobe, a token index, one write data bit and one read data bit.

When both ports ask for the same free token in the same cycle, exactly one of them receives it, and the left port always wins. A claim that cannot be granted straight away stays pending. The waiting port becomes the owner on the same clock edge at which the current owner lets the token go. A read returns that port's own view of the token. The value is 0 when the reading port holds it and 1 when the token is free or held by the other side.

Top module: `hw_sem_array`

## Requirements
- R1: After reset every token is free and both read data outputs are 1.
- R2: A port performs an access only in a cycle where its select is 1 and its chip enable is 0. In any other cycle its write has no effect on any token.
- R3: A write of 0 (a claim) to a free token makes the writing port its owner. A read by that port then returns 0.
- R4: A read of a token that the other port holds returns 1.
- R5: When both ports claim the same free token in the same cycle, the left port becomes owner and the right port does not. Ownership is never held by both ports at once.
- R6: A claim on a token held by the other port stays pending. The claiming port becomes the owner on the clock edge at which the owner writes 1 to that token, including when the release and a fresh claim arrive in the same cycle.
- R7: A write of 1 to a token by a port that does not own it has no effect.
- R8: A write of 1 by the owner frees the token when nobody is waiting for it. Both ports then read it as 1.
- R9: The 3-bit index selects one of eight tokens (0 to 7), and tokens change state independently of each other.
- R10: Read data is registered. It updates on the clock edge that ends a read access (select 1, chip enable 0, write strobe 0) and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left semaphore select, active high |
| l_ce | input | 1 | Left memory chip enable, active high; blocks token access |
| l_wr | input | 1 | Left write strobe (1 write, 0 read) |
| l_wdata | input | 1 | Left write data: 0 claims, 1 releases |
| l_idx | input | 3 | Left token index |
| l_rdata | output | 1 | Left registered token view |
| r_sel | input | 1 | Right semaphore select, active high |
| r_ce | input | 1 | Right memory chip enable, active high; blocks token access |
| r_wr | input | 1 | Right write strobe (1 write, 0 read) |
| r_wdata | input | 1 | Right write data: 0 claims, 1 releases |
| r_idx | input | 3 | Right token index |
| r_rdata | output | 1 | Right registered token view |

## Verification
A claim or release presented in cycle N changes ownership on the edge that ends cycle N. A read presented in cycle N+1 reports the updated view on the edge that ends N+1. The bench therefore drives each stimulus on a falling edge and samples both read outputs on the next falling edge, one clock after the read is issued. Rows that perform no read expect the earlier read value to be held. Every step is therefore a single-cycle check of exactly one register stage.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int NSIDE = 2;
  typedef enum int {SIDE_L = 0, SIDE_R = 1} side_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NTOK = 8,
  localparam int IW = $clog2(NTOK)
) (
  input  logic            sel,
  input  logic            ce,
  input  logic            wr,
  input  logic            wd,
  input  logic [IW-1:0]   idx,
  output logic [NTOK-1:0] claim,
  output logic [NTOK-1:0] free,
  output logic            rd_en
);
  logic act;
  assign act   = sel & ~ce;
  assign rd_en = act & ~wr;

  for (genvar t = 0; t < NTOK; t++) begin : g_hit
    logic hit;
    assign hit      = act & wr & (idx == IW'(t));
    assign claim[t] = hit & ~wd;
    assign free[t]  = hit & wd;
  end
endmodule

// File: rtl/sem_token_cell.sv
module sem_token_cell (
  input  logic clk,
  input  logic rst,
  input  logic claim_l,
  input  logic free_l,
  input  logic claim_r,
  input  logic free_r,
  output logic own_l,
  output logic own_r
);
  logic wait_l_q, wait_r_q;
  logic own_l_n, own_r_n, wait_l_n, wait_r_n;
  logic open, want_l, want_r;

  always_comb begin
    open    = (~own_l & ~own_r) | (free_l & own_l) | (free_r & own_r);
    want_l  = (claim_l | wait_l_q) & ~own_l;
    want_r  = (claim_r | wait_r_q) & ~own_r;
    own_l_n = own_l;
    own_r_n = own_r;
    if (open) begin
      own_l_n = want_l;
      own_r_n = want_r & ~want_l;
    end
    wait_l_n = want_l & ~own_l_n;
    wait_r_n = want_r & ~own_r_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_l    <= 1'b0;
      own_r    <= 1'b0;
      wait_l_q <= 1'b0;
      wait_r_q <= 1'b0;
    end else begin
      own_l    <= own_l_n;
      own_r    <= own_r_n;
      wait_l_q <= wait_l_n;
      wait_r_q <= wait_r_n;
    end
  end
endmodule

// File: rtl/sem_view_reg.sv
module sem_view_reg #(
  parameter int NTOK = 8,
  localparam int IW = $clog2(NTOK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [IW-1:0]   idx,
  input  logic [NTOK-1:0] mine,
  output logic            rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= 1'b1;
    else if (rd_en) rdata <= ~mine[idx];
  end
endmodule

// File: rtl/hw_sem_array.sv
module hw_sem_array #(
  parameter int NTOK = 8,
  localparam int IW = $clog2(NTOK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_sel,
  input  logic          l_ce,
  input  logic          l_wr,
  input  logic          l_wdata,
  input  logic [IW-1:0] l_idx,
  output logic          l_rdata,
  input  logic          r_sel,
  input  logic          r_ce,
  input  logic          r_wr,
  input  logic          r_wdata,
  input  logic [IW-1:0] r_idx,
  output logic          r_rdata
);
  import sem_pkg::*;

  logic [NSIDE-1:0]  sel_v, ce_v, wr_v, wd_v, rd_v, rdat_v;
  logic [IW-1:0]     idx_v [NSIDE];
  logic [NTOK-1:0]   claim_v [NSIDE];
  logic [NTOK-1:0]   free_v  [NSIDE];
  logic [NTOK-1:0]   own_v   [NSIDE];
  logic [NTOK-1:0]   own_l, own_r;

  assign sel_v = {r_sel, l_sel};
  assign ce_v  = {r_ce, l_ce};
  assign wr_v  = {r_wr, l_wr};
  assign wd_v  = {r_wdata, l_wdata};
  assign idx_v[SIDE_L] = l_idx;
  assign idx_v[SIDE_R] = r_idx;
  assign l_rdata = rdat_v[SIDE_L];
  assign r_rdata = rdat_v[SIDE_R];
  assign own_l = own_v[SIDE_L];
  assign own_r = own_v[SIDE_R];

  for (genvar p = 0; p < NSIDE; p++) begin : g_side
    sem_port_dec #(.NTOK(NTOK)) u_dec (
      .sel(sel_v[p]), .ce(ce_v[p]), .wr(wr_v[p]), .wd(wd_v[p]),
      .idx(idx_v[p]), .claim(claim_v[p]), .free(free_v[p]), .rd_en(rd_v[p])
    );
    sem_view_reg #(.NTOK(NTOK)) u_view (
      .clk(clk), .rst(rst), .rd_en(rd_v[p]), .idx(idx_v[p]),
      .mine(own_v[p]), .rdata(rdat_v[p])
    );
  end

  for (genvar t = 0; t < NTOK; t++) begin : g_tok
    sem_token_cell u_cell (
      .clk(clk), .rst(rst),
      .claim_l(claim_v[SIDE_L][t]), .free_l(free_v[SIDE_L][t]),
      .claim_r(claim_v[SIDE_R][t]), .free_r(free_v[SIDE_R][t]),
      .own_l(own_v[SIDE_L][t]), .own_r(own_v[SIDE_R][t])
    );
  end
endmodule

// File: rtl/sem_array_chk.sv
module sem_array_chk #(
  parameter int NTOK = 8,
  localparam int IW = $clog2(NTOK)
) (
  input logic          clk,
  input logic          rst,
  input logic          l_sel,
  input logic          l_ce,
  input logic          l_wr,
  input logic          l_wdata,
  input logic [IW-1:0] l_idx,
  input logic          l_rdata,
  input logic          r_sel,
  input logic          r_ce,
  input logic          r_wr,
  input logic          r_wdata,
  input logic [IW-1:0] r_idx,
  input logic          r_rdata,
  input logic [NTOK-1:0] own_l,
  input logic [NTOK-1:0] own_r
);
  logic l_act, r_act;
  assign l_act = l_sel & ~l_ce;
  assign r_act = r_sel & ~r_ce;

  p_reset_free_r1: assert property (@(posedge clk)
    rst |=> (own_l == '0 && own_r == '0 && l_rdata && r_rdata));

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!l_act && !r_act) |=> ($stable(own_l) && $stable(own_r)));

  p_left_grant_r3: assert property (@(posedge clk) disable iff (rst)
    (l_act && l_wr && !l_wdata && !own_l[l_idx] && !own_r[l_idx])
      |=> own_l[$past(l_idx)]);

  p_left_view_r3: assert property (@(posedge clk) disable iff (rst)
    (l_act && !l_wr) |=> (l_rdata == !$past(own_l[l_idx])));

  p_right_view_r4: assert property (@(posedge clk) disable iff (rst)
    (r_act && !r_wr) |=> (r_rdata == !$past(own_r[r_idx])));

  p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    (own_l & own_r) == '0);

  p_foreign_release_r7: assert property (@(posedge clk) disable iff (rst)
    (r_act && r_wr && r_wdata && own_l[r_idx] &&
     !(l_act && l_wr && l_wdata && l_idx == r_idx))
      |=> own_l[$past(r_idx)]);

  p_hold_view_r10: assert property (@(posedge clk) disable iff (rst)
    !(l_act && !l_wr) |=> $stable(l_rdata));
endmodule

bind hw_sem_array sem_array_chk #(.NTOK(NTOK)) u_chk (.*);

// File: tb/tb_hw_sem_array.sv
module tb_hw_sem_array;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_ce = 0, l_wr = 0, l_wdata = 0;
  logic r_sel = 0, r_ce = 0, r_wr = 0, r_wdata = 0;
  logic [2:0] l_idx = 0, r_idx = 0;
  logic l_rdata, r_rdata;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  hw_sem_array dut (.*);

  // op field: {sel, ce, wr, wdata, idx[2:0]}
  function automatic logic [6:0] rd(input int i);  return {4'b1000, 3'(i)}; endfunction
  function automatic logic [6:0] rq(input int i);  return {4'b1010, 3'(i)}; endfunction
  function automatic logic [6:0] rl(input int i);  return {4'b1011, 3'(i)}; endfunction
  function automatic logic [6:0] ceq(input int i); return {4'b1110, 3'(i)}; endfunction
  function automatic logic [6:0] nsq(input int i); return {4'b0010, 3'(i)}; endfunction
  localparam logic [6:0] NOP = 7'd0;

  localparam int NV = 21;
  // row: {left op, right op, expected l_rdata, expected r_rdata}
  localparam logic [15:0] VEC [NV] = '{
    {rq(0),  NOP,    2'b11},  // R3 left claims 0
    {rd(0),  rd(0),  2'b01},  // R3 R4
    {NOP,    rq(0),  2'b01},  // R6 right waits
    {NOP,    rd(0),  2'b01},  // R6 still not owner
    {NOP,    rl(0),  2'b01},  // R7 foreign release
    {rd(0),  rd(0),  2'b01},  // R7 left keeps 0
    {rl(0),  NOP,    2'b01},  // R10 no read, values hold
    {rd(0),  rd(0),  2'b10},  // R6 handed to right
    {NOP,    rl(0),  2'b10},  // R8 right frees
    {rd(0),  rd(0),  2'b11},  // R8 free
    {rq(3),  rq(3),  2'b11},  // R5 collision
    {rd(3),  rd(3),  2'b01},  // R5 left wins
    {ceq(5), ceq(5), 2'b01},  // R2 chip enable blocks, R10 hold
    {rd(5),  rd(5),  2'b11},  // R2 token 5 free
    {nsq(6), NOP,    2'b11},  // R2 no select
    {rd(6),  rd(6),  2'b11},  // R2 token 6 free
    {rq(7),  rq(6),  2'b11},  // R9 different tokens
    {rd(7),  rd(6),  2'b00},  // R9
    {rd(6),  rd(7),  2'b11},  // R9 cross view
    {rq(6),  rl(6),  2'b11},  // R6 release and claim together
    {rd(6),  rd(6),  2'b01}   // R6 left owns 6
  };
  localparam int TAG [NV] = '{3,4,6,6,7,7,10,6,8,8,5,5,2,2,2,2,9,9,9,6,6};

  task automatic check(input string rq_tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", rq_tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] lo, input logic [6:0] ro);
    {l_sel, l_ce, l_wr, l_wdata, l_idx} = lo;
    {r_sel, r_ce, r_wr, r_wdata, r_idx} = ro;
  endtask

  task automatic step(input logic [6:0] lo, input logic [6:0] ro);
    drive(lo, ro);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 left after reset", l_rdata, 1'b1);
    check("R1 right after reset", r_rdata, 1'b1);
    for (int i = 0; i < NV; i++) begin
      string t;
      step(VEC[i][15:9], VEC[i][8:2]);
      t = $sformatf("R%0d row %0d", TAG[i], i);
      check({t, " left"},  l_rdata, VEC[i][1]);
      check({t, " right"}, r_rdata, VEC[i][0]);
    end
    // R1: reset in mid-run clears held tokens 6 and 7
    rst = 1'b1;
    step(NOP, NOP);
    rst = 1'b0;
    check("R1 left after mid reset", l_rdata, 1'b1);
    step(rd(7), rd(6));
    check("R1 token 7 free", l_rdata, 1'b1);
    check("R1 token 6 free", r_rdata, 1'b1);
    // R3: owner re-claim keeps ownership; R10 holds across idle
    step(NOP, rq(2));
    step(NOP, rq(2));
    step(rd(2), rd(2));
    check("R3 right re-claim", r_rdata, 1'b0);
    check("R4 left sees held", l_rdata, 1'b1);
    step(NOP, NOP);
    check("R10 right hold", r_rdata, 1'b0);
    step(NOP, NOP);
    finish_run();
  end
endmodule